// File: doc/BRIEF.md
# NAND Identification and Parameter Page Responder

This block is the device-side answer logic for the two identification reads of a NAND flash device. It is meant for a synthesizable flash model or an emulation front end. It watches the command and address write strobes on a byte-wide bus. Opcode 90h followed by address 00h selects the identification read. Opcode ECh followed by address 00h selects the parameter-page read. After either sequence, each read strobe returns the next byte from a table of constants.

The parameter page is 256 bytes long and holds the device's organisation and a CRC-16 in its last two bytes. The block serves it three times in a row, and every byte after the third copy reads FFh. A read mode, once entered, stays active until the host writes another command. While the identification read is active, a status opcode (70h) is refused, so the host has to write a dummy 00h command first.

Read strobes are one clock wide and stand for RE# falling edges. Write strobes stand for WE# rising edges. One parameter picks which of the two stacked-die identification codes the block reports.

Top module: `nand_ident_resp`

## Requirements
- R1: After reset `io_o` is 00h and no read mode is active.
- R2: Command 90h followed by address 00h starts the identification read. Successive read strobes return 01h, DCh, 90h, 95h, 54h when `ONE_CE` = 0, and 01h, D3h, D1h, 95h, 58h when `ONE_CE` = 1. Any read after the fifth byte returns 00h.
- R3: In the fifth identification byte, bits 6:4 hold the plane-size code 101b and bits 3:2 hold the plane-count code. The code is 01b (four planes) when `ONE_CE` = 0 and 10b (eight planes) when `ONE_CE` = 1. Bits 7 and 1:0 are zero.
- R4: Command ECh followed by address 00h starts the parameter-page read. Page bytes 0 to 3 are 4Fh, 4Eh, 46h, 49h. The other fields are:
  - byte 4 = 02h (revision)
  - byte 64 = 01h (manufacturer)
  - bytes 80..83 = 00h, 08h, 00h, 00h (2048 data bytes per page)
  - byte 84 = 40h (spare bytes)
  - byte 92 = 40h (pages per block)
  - byte 97 = 10h (4096 blocks)
  - byte 100 = 02h (units)
  - byte 101 = 23h (address cycles)
  - byte 102 = 01h (bits per cell)
  - byte 112 = 01h (ECC bits)
  - every other byte below 254 = 00h.
- R5: Bytes 256..511 and 512..767 repeat bytes 0..255 exactly. Every byte from 768 on reads FFh. The byte pointer saturates at 1023, and further reads keep returning FFh.
- R6: Byte 254 is the low byte and byte 255 the high byte of a CRC-16 over bytes 0..253. The CRC uses polynomial 8005h and seed 4F4Eh, with each byte fed in MSB first and no reflection.
- R7: A read mode persists until a command is latched. Every latched command except the refused one in R8 clears the byte pointer. Opcode 90h or ECh arms the matching read. Any other opcode returns the block to idle.
- R8: While the identification read is active, command 70h has no effect on the mode or the pointer. A dummy 00h command ends the identification read.
- R9: An address byte other than 00h after 90h or ECh returns the block to idle. An address strobe in any other mode has no effect.
- R10: A read strobe while the block is idle or armed returns 00h.
- R11: `io_o` changes only on a read strobe. A read strobe in the same cycle as `we_i` is ignored. A write strobe with `cle_i` and `ale_i` both high or both low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cle_i | input | 1 | Command latch qualifier |
| ale_i | input | 1 | Address latch qualifier |
| we_i | input | 1 | One-cycle write strobe |
| re_i | input | 1 | One-cycle read strobe |
| io_i | input | 8 | Command or address byte |
| io_o | output | 8 | Last byte read out |

## Verification
Errors in the mode register or the byte pointer only become visible on the next read strobe. A mode that is wrong after the refused 70h or after a bad address shows up as 00h where a table byte was expected, or the reverse, one clock after that read. A pointer that is wrong by one shifts every later byte. The bench therefore reads long unbroken runs: the whole identification sequence, and more than four copies' worth of the parameter page. A stale or wrong CRC constant shows in bytes 254/255 of every copy.

// File: rtl/nand_ident_pkg.sv
package nand_ident_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_ID_ARM = 3'd1,
    MODE_PP_ARM = 3'd2,
    MODE_ID     = 3'd3,
    MODE_PP     = 3'd4
  } mode_e;

  localparam logic [7:0] OP_ID     = 8'h90;
  localparam logic [7:0] OP_PP     = 8'hEC;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] ADDR_ZERO = 8'h00;

  localparam logic [2:0]  PLANE_SIZE_CODE = 3'b101;
  localparam logic [1:0]  PLANES4_CODE    = 2'b01;
  localparam logic [1:0]  PLANES8_CODE    = 2'b10;
  localparam logic [15:0] CRC_POLY        = 16'h8005;
  localparam logic [15:0] CRC_SEED        = 16'h4F4E;
  localparam int unsigned CRC_SPAN        = 254;

  function automatic logic [7:0] id_byte(int unsigned i, bit one_ce);
    logic [7:0] b;
    case (i)
      0:       b = 8'h01;
      1:       b = one_ce ? 8'hD3 : 8'hDC;
      2:       b = one_ce ? 8'hD1 : 8'h90;
      3:       b = 8'h95;
      4:       b = {1'b0, PLANE_SIZE_CODE, one_ce ? PLANES8_CODE : PLANES4_CODE, 2'b00};
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  // page content without the CRC field
  function automatic logic [7:0] pp_base(int unsigned i);
    logic [7:0] b;
    case (i)
      0:       b = 8'h4F;
      1:       b = 8'h4E;
      2:       b = 8'h46;
      3:       b = 8'h49;
      4:       b = 8'h02;
      64:      b = 8'h01;
      81:      b = 8'h08;
      84:      b = 8'h40;
      92:      b = 8'h40;
      97:      b = 8'h10;
      100:     b = 8'h02;
      101:     b = 8'h23;
      102:     b = 8'h01;
      112:     b = 8'h01;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic [15:0] pp_crc();
    logic [15:0] c;
    c = CRC_SEED;
    for (int unsigned i = 0; i < CRC_SPAN; i++) begin
      c = c ^ {pp_base(i), 8'h00};
      for (int k = 0; k < 8; k++) begin
        c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/nand_ident_mode_fsm.sv
module nand_ident_mode_fsm
  import nand_ident_pkg::*;
#(
  parameter int unsigned PTR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_stb_i,
  input  logic             addr_stb_i,
  input  logic             rd_stb_i,
  input  logic [7:0]       io_i,
  output mode_e            mode_o,
  output logic [PTR_W-1:0] ptr_o
);

  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  mode_e            mode_q;
  logic [PTR_W-1:0] ptr_q;
  logic             refuse;
  logic             reading;

  assign refuse  = (mode_q == MODE_ID) && (io_i == OP_STATUS);
  assign reading = (mode_q == MODE_ID) || (mode_q == MODE_PP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      ptr_q  <= '0;
    end else if (cmd_stb_i) begin
      if (!refuse) begin
        ptr_q <= '0;
        case (io_i)
          OP_ID:   mode_q <= MODE_ID_ARM;
          OP_PP:   mode_q <= MODE_PP_ARM;
          default: mode_q <= MODE_IDLE;
        endcase
      end
    end else if (addr_stb_i) begin
      if (mode_q == MODE_ID_ARM) begin
        mode_q <= (io_i == ADDR_ZERO) ? MODE_ID : MODE_IDLE;
      end else if (mode_q == MODE_PP_ARM) begin
        mode_q <= (io_i == ADDR_ZERO) ? MODE_PP : MODE_IDLE;
      end
    end else if (rd_stb_i && reading && (ptr_q != PTR_MAX)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign ptr_o  = ptr_q;

endmodule

// File: rtl/nand_ident_rom.sv
module nand_ident_rom
  import nand_ident_pkg::*;
#(
  parameter int unsigned PTR_W    = 10,
  parameter int unsigned PAGE_LEN = 256,
  parameter int unsigned COPIES   = 3,
  parameter int unsigned ID_LEN   = 5,
  parameter bit          ONE_CE   = 1'b0
) (
  input  mode_e            mode_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [7:0]       byte_o
);

  localparam int unsigned      IDX_W   = $clog2(PAGE_LEN);
  localparam logic [PTR_W-1:0] PP_END  = PTR_W'(PAGE_LEN * COPIES);
  localparam logic [PTR_W-1:0] ID_END  = PTR_W'(ID_LEN);
  localparam logic [15:0]      PP_CRC  = pp_crc();
  localparam logic [IDX_W-1:0] CRC_LO  = IDX_W'(PAGE_LEN - 2);
  localparam logic [IDX_W-1:0] CRC_HI  = IDX_W'(PAGE_LEN - 1);

  logic [7:0]       id_b;
  logic [7:0]       pp_b;
  logic [IDX_W-1:0] idx;

  assign idx = ptr_i[IDX_W-1:0];

  if (ONE_CE) begin : g_one_ce
    always_comb id_b = (ptr_i < ID_END) ? id_byte(32'(ptr_i), 1'b1) : 8'h00;
  end else begin : g_two_ce
    always_comb id_b = (ptr_i < ID_END) ? id_byte(32'(ptr_i), 1'b0) : 8'h00;
  end

  always_comb begin
    if (ptr_i >= PP_END)     pp_b = 8'hFF;
    else if (idx == CRC_LO)  pp_b = PP_CRC[7:0];
    else if (idx == CRC_HI)  pp_b = PP_CRC[15:8];
    else                     pp_b = pp_base(32'(idx));
  end

  always_comb begin
    case (mode_i)
      MODE_ID: byte_o = id_b;
      MODE_PP: byte_o = pp_b;
      default: byte_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/nand_ident_resp.sv
module nand_ident_resp
  import nand_ident_pkg::*;
#(
  parameter int unsigned PTR_W    = 10,
  parameter int unsigned PAGE_LEN = 256,
  parameter int unsigned COPIES   = 3,
  parameter int unsigned ID_LEN   = 5,
  parameter bit          ONE_CE   = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o
);

  logic             cmd_stb;
  logic             addr_stb;
  logic             rd_stb;
  mode_e            mode_q;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       rom_b;
  logic [7:0]       io_q;

  assign cmd_stb  = we_i & cle_i & ~ale_i;
  assign addr_stb = we_i & ale_i & ~cle_i;
  assign rd_stb   = re_i & ~we_i;

  nand_ident_mode_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_stb_i (cmd_stb),
    .addr_stb_i(addr_stb),
    .rd_stb_i  (rd_stb),
    .io_i      (io_i),
    .mode_o    (mode_q),
    .ptr_o     (ptr_q)
  );

  nand_ident_rom #(
    .PTR_W   (PTR_W),
    .PAGE_LEN(PAGE_LEN),
    .COPIES  (COPIES),
    .ID_LEN  (ID_LEN),
    .ONE_CE  (ONE_CE)
  ) u_rom (
    .mode_i(mode_q),
    .ptr_i (ptr_q),
    .byte_o(rom_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     io_q <= 8'h00;
    else if (rd_stb) io_q <= rom_b;
  end

  assign io_o = io_q;

endmodule

// File: rtl/nand_ident_resp_chk.sv
module nand_ident_resp_chk
  import nand_ident_pkg::*;
#(
  parameter int unsigned PTR_W  = 10,
  parameter int unsigned PP_END = 768
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cle_i,
  input logic             ale_i,
  input logic             we_i,
  input logic             re_i,
  input logic [7:0]       io_i,
  input logic [7:0]       io_o,
  input mode_e            mode_i,
  input logic [PTR_W-1:0] ptr_i
);

  logic rd, cmd, adr, rd_mode;
  assign rd      = re_i && !we_i;
  assign cmd     = we_i && cle_i && !ale_i;
  assign adr     = we_i && ale_i && !cle_i;
  assign rd_mode = (mode_i == MODE_ID) || (mode_i == MODE_PP);

  // R11
  io_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(io_o));

  // R10
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !rd_mode) |=> io_o == 8'h00);

  // R5
  pp_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && mode_i == MODE_PP && ptr_i >= PTR_W'(PP_END)) |=> io_o == 8'hFF);

  // R2
  id_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && mode_i == MODE_ID && ptr_i == '0) |=> io_o == 8'h01);

  // R4
  pp_sig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && mode_i == MODE_PP && ptr_i == '0) |=> io_o == 8'h4F);

  // R7
  cmd_ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd && !(mode_i == MODE_ID && io_i == OP_STATUS)) |=> ptr_i == '0);

  // R8
  status_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd && mode_i == MODE_ID && io_i == OP_STATUS) |=> (mode_i == MODE_ID) && $stable(ptr_i));

  // R9
  bad_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adr && (mode_i == MODE_ID_ARM || mode_i == MODE_PP_ARM) && io_i != 8'h00) |=> mode_i == MODE_IDLE);

endmodule

bind nand_ident_resp nand_ident_resp_chk #(
  .PTR_W (PTR_W),
  .PP_END(PAGE_LEN * COPIES)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cle_i (cle_i),
  .ale_i (ale_i),
  .we_i  (we_i),
  .re_i  (re_i),
  .io_i  (io_i),
  .io_o  (io_o),
  .mode_i(mode_q),
  .ptr_i (ptr_q)
);

// File: tb/nand_ident_resp_test.sv
module nand_ident_resp_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cle = 0, ale = 0, we = 0, re = 0;
  logic [7:0] din = 8'h00;
  logic [7:0] io_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string cur_req = "R1";

  // reference model state
  int         m_mode = 0; // 0 idle 1 id-arm 2 pp-arm 3 id 4 pp
  int         m_ptr  = 0;
  logic [7:0] exp_io = 8'h00;
  logic [15:0] ref_crc;
  logic [7:0]  ref_id [5] = '{8'h01, 8'hDC, 8'h90, 8'h95, 8'h54};

  always #4 clk = ~clk;

  nand_ident_resp uut (
    .clk_i(clk), .rst_ni(rst_ni), .cle_i(cle), .ale_i(ale),
    .we_i(we), .re_i(re), .io_i(din), .io_o(io_o)
  );

  function automatic logic [7:0] ref_field(int i);
    case (i)
      0: return 8'h4F;  1: return 8'h4E;  2: return 8'h46;  3: return 8'h49;
      4: return 8'h02;  64: return 8'h01; 81: return 8'h08; 84: return 8'h40;
      92: return 8'h40; 97: return 8'h10; 100: return 8'h02; 101: return 8'h23;
      102: return 8'h01; 112: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ref_pp(int i);
    int j;
    if (i >= 768) return 8'hFF;
    j = i % 256;
    if (j == 254) return ref_crc[7:0];
    if (j == 255) return ref_crc[15:8];
    return ref_field(j);
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] want);
    vectors++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: io_o=%02h expected %02h", req, got, want);
    end
  endtask

  task automatic step(logic c, logic a, logic w, logic r, logic [7:0] d);
    @(negedge clk);
    chk(cur_req, io_o, exp_io);
    cle = c; ale = a; we = w; re = r; din = d;
    if (w && c && !a) begin
      if (!(m_mode == 3 && d == 8'h70)) begin
        m_ptr  = 0;
        m_mode = (d == 8'h90) ? 1 : (d == 8'hEC) ? 2 : 0;
      end
    end else if (w && a && !c) begin
      if (m_mode == 1) m_mode = (d == 8'h00) ? 3 : 0;
      else if (m_mode == 2) m_mode = (d == 8'h00) ? 4 : 0;
    end else if (r && !w) begin
      if (m_mode == 3) exp_io = (m_ptr < 5) ? ref_id[m_ptr] : 8'h00;
      else if (m_mode == 4) exp_io = ref_pp(m_ptr);
      else exp_io = 8'h00;
      if ((m_mode == 3 || m_mode == 4) && m_ptr < 1023) m_ptr++;
    end
    @(posedge clk);
    #1;
    cle = 0; ale = 0; we = 0; re = 0; din = 8'h00;
  endtask

  task automatic cmd(logic [7:0] d);  step(1, 0, 1, 0, d); endtask
  task automatic addr(logic [7:0] d); step(0, 1, 1, 0, d); endtask
  task automatic rd();                step(0, 0, 0, 1, 8'h00); endtask

  task automatic rd_chk(string req, logic [7:0] want);
    rd();
    @(negedge clk);
    chk(req, io_o, want);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b5;
    ref_crc = 16'h4F4E;
    for (int i = 0; i < 254; i++) begin
      ref_crc = ref_crc ^ {ref_field(i), 8'h00};
      for (int k = 0; k < 8; k++)
        ref_crc = ref_crc[15] ? ((ref_crc << 1) ^ 16'h8005) : (ref_crc << 1);
    end

    repeat (3) @(negedge clk);
    chk("R1", io_o, 8'h00);
    rst_ni = 1'b1;
    cur_req = "R10";
    rd_chk("R1", 8'h00);
    rd_chk("R10", 8'h00);

    // identification read
    cur_req = "R2";
    cmd(8'h90);
    rd_chk("R10", 8'h00); // armed, no address yet
    addr(8'h00);
    rd_chk("R2", 8'h01);
    rd_chk("R2", 8'hDC);
    rd_chk("R2", 8'h90);
    rd_chk("R2", 8'h95);
    rd();
    @(negedge clk);
    b5 = io_o;
    chk("R2", b5, 8'h54);
    chk("R3", {6'b0, b5[3:2]}, 8'h01);
    chk("R3", {5'b0, b5[6:4]}, 8'h05);
    chk("R3", {7'b0, b5[7]} | {6'b0, b5[1:0]}, 8'h00);
    rd_chk("R2", 8'h00);
    rd_chk("R2", 8'h00);

    // refused status, then dummy
    cur_req = "R8";
    cmd(8'h90); addr(8'h00);
    rd_chk("R8", 8'h01);
    rd_chk("R8", 8'hDC);
    cmd(8'h70);
    rd_chk("R8", 8'h90);
    cmd(8'h00);
    rd_chk("R8", 8'h00);
    cmd(8'h70);
    rd_chk("R7", 8'h00);

    // bad address, stray address
    cur_req = "R9";
    cmd(8'h90); addr(8'h01);
    rd_chk("R9", 8'h00);
    cmd(8'hEC); addr(8'h80);
    rd_chk("R9", 8'h00);
    cmd(8'h90); addr(8'h00);
    addr(8'h05);
    rd_chk("R9", 8'h01);

    // ignored strobes
    cur_req = "R11";
    step(1, 1, 1, 0, 8'hEC);      // both qualifiers high
    step(0, 0, 1, 0, 8'hEC);      // data write
    step(0, 0, 1, 1, 8'h00);      // read with write
    @(negedge clk);
    chk("R11", io_o, 8'h01);
    rd_chk("R11", 8'hDC);

    // parameter page, full sweep past saturation
    cur_req = "R5";
    cmd(8'hEC); addr(8'h00);
    for (int i = 0; i < 1030; i++) begin
      case (i)
        0:    rd_chk("R4", 8'h4F);
        1:    rd_chk("R4", 8'h4E);
        2:    rd_chk("R4", 8'h46);
        3:    rd_chk("R4", 8'h49);
        4:    rd_chk("R4", 8'h02);
        81:   rd_chk("R4", 8'h08);
        101:  rd_chk("R4", 8'h23);
        254:  rd_chk("R6", ref_crc[7:0]);
        255:  rd_chk("R6", ref_crc[15:8]);
        256:  rd_chk("R5", 8'h4F);
        510:  rd_chk("R5", ref_crc[7:0]);
        512:  rd_chk("R5", 8'h4F);
        767:  rd_chk("R5", ref_crc[15:8]);
        768:  rd_chk("R5", 8'hFF);
        1029: rd_chk("R5", 8'hFF);
        default: rd();
      endcase
    end

    // new command restarts pointer mid-page
    cur_req = "R7";
    cmd(8'hEC); addr(8'h00);
    for (int i = 0; i < 10; i++) rd();
    cmd(8'hEC); addr(8'h00);
    rd_chk("R7", 8'h4F);
    cmd(8'h90); addr(8'h00);
    rd_chk("R7", 8'h01);
    cmd(8'h30);
    rd_chk("R7", 8'h00);

    step(0, 0, 0, 0, 8'h00);
    finish_run();
  end

endmodule